// File: doc/BRIEF.md
# Snooping Invalidation Coherence Controller

This block models invalidation-based coherence for a single shared memory word that is cached privately by two to four agents on one common bus. Each agent issues processor reads and writes against its own copy. Coherence status lives with each copy and is not kept in any central table. A fixed-priority arbiter grants one agent per cycle, and the granted request becomes that cycle's bus transaction. A small backing-store model holds the memory value.

A parameter picks the write policy. In write-through mode memory follows every write, and copies are never dirty. In write-back mode a writer keeps the only up-to-date value in a Modified copy. Memory is refreshed only when another agent misses and the owner supplies the data.

Top module: `snoop_inval_ctrl`

## Requirements
- R1: While reset is held and directly after it, every line is Invalid and clean, every line_data is 0, mem_value equals MEM_INIT and bus_op is idle (code 0).
- R2: A granted read to an Invalid line drives bus_op = 1 (miss) in that cycle. After the clock edge the line is valid and clean and holds the current word value.
- R3: A granted read to a valid line drives bus_op = 0 and changes no line state and no memory.
- R4: A granted write drives bus_op = 2 (invalidate) unless the writer already holds the word Modified. After the edge the writer holds the written data and every other line is Invalid.
- R5: In write-through mode (WRITE_BACK = 0), mem_value equals the written data after the edge of the write transaction, and the writer's line is clean.
- R6: In write-back mode (WRITE_BACK = 1), a write leaves mem_value unchanged and marks the writer's line dirty (Modified).
- R7: In write-back mode, a miss while another line is Modified fills the requester with the owner's data. In the same transaction mem_value takes that data, and the former owner keeps a valid, clean copy.
- R8: In write-back mode, a write by an agent whose line is already Modified drives bus_op = 0, updates that line's data and leaves mem_value unchanged.
- R9: grant is one-hot or zero, goes only to a requesting agent and goes to the lowest-indexed requester. When any request is present, some agent is granted. An ungranted agent keeps its request, and it is served in a later cycle.
- R10: In write-through mode no line is ever dirty, and every valid line holds the same value as mem_value.
- R11: At most one line is dirty at any time, and a dirty line is always valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CACHES | Per-agent request, held until granted |
| req_write | input | NUM_CACHES | Per-agent request kind: 1 write, 0 read |
| req_wdata | input | NUM_CACHES*DATA_W | Per-agent write data, agent i in slice i |
| grant | output | NUM_CACHES | One-hot agent served this cycle |
| bus_op | output | 2 | Transaction this cycle: 0 idle, 1 miss, 2 invalidate |
| line_valid | output | NUM_CACHES | Per-line valid (Shared or Modified) |
| line_dirty | output | NUM_CACHES | Per-line Modified flag |
| line_data | output | NUM_CACHES*DATA_W | Per-line cached value, line i in slice i |
| mem_value | output | DATA_W | Backing memory contents |

## Verification
A line left valid after a foreign write would show up one edge later as a second line_valid bit, or as a line_data value that differs from the newest write. The invalidate check on the next cycle catches it at once. A lost dirty flag in write-back mode would let a later miss pick up the stale mem_value, so a wrong fill value appears on the edge after that miss. A wrong arbiter or wrong state lookup changes grant or bus_op in the same cycle as the request, before any edge.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

   typedef enum logic [1:0] {
      BUS_IDLE  = 2'd0,
      BUS_MISS  = 2'd1,
      BUS_INVAL = 2'd2
   } bus_op_e;

   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_SHR = 2'd1,
      LN_MOD = 2'd2
   } line_st_e;

endpackage

// File: rtl/snoop_prio_arb.sv
module snoop_prio_arb #(
   parameter int N = 3
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   // Lowest index wins; a thermometer of "already taken" ripples upward.
   logic [N:0] taken;

   assign taken[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_slot
      assign gnt[i]     = req[i] & ~taken[i];
      assign taken[i+1] = taken[i] | req[i];
   end

endmodule

// File: rtl/snoop_line.sv
module snoop_line
   import snoop_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit WRITE_BACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              own_gnt,
   input  logic              own_write,
   input  logic [DATA_W-1:0] own_wdata,
   input  logic [DATA_W-1:0] fill_data,
   input  bus_op_e           bus_op,
   output line_st_e          st,
   output logic [DATA_W-1:0] val
);
   localparam line_st_e WR_ST = WRITE_BACK ? LN_MOD : LN_SHR;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= LN_INV;
         val <= '0;
      end else if (own_gnt) begin
         if (own_write) begin
            val <= own_wdata;
            st  <= WR_ST;
         end else if (st == LN_INV) begin
            val <= fill_data;
            st  <= LN_SHR;
         end
      end else if (bus_op == BUS_INVAL) begin
         st <= LN_INV;
      end else if (bus_op == BUS_MISS && st == LN_MOD) begin
         st <= LN_SHR;
      end
   end

endmodule

// File: rtl/snoop_backing.sv
module snoop_backing
   import snoop_pkg::*;
#(
   parameter int              DATA_W     = 8,
   parameter bit              WRITE_BACK = 1'b1,
   parameter logic [DATA_W-1:0] MEM_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_op_e           bus_op,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              owner_hit,
   input  logic [DATA_W-1:0] owner_data,
   output logic [DATA_W-1:0] mem
);
   if (WRITE_BACK) begin : g_wb
      // Memory refreshed only when a dirty owner supplies a miss.
      always_ff @(posedge clk) begin
         if (!rst_n)                              mem <= MEM_INIT;
         else if (bus_op == BUS_MISS && owner_hit) mem <= owner_data;
      end
   end else begin : g_wt
      // Memory follows every invalidating write.
      always_ff @(posedge clk) begin
         if (!rst_n)                  mem <= MEM_INIT;
         else if (bus_op == BUS_INVAL) mem <= wr_data;
      end
   end

endmodule

// File: rtl/snoop_inval_ctrl.sv
module snoop_inval_ctrl
   import snoop_pkg::*;
#(
   parameter int                NUM_CACHES = 3,
   parameter int                DATA_W     = 8,
   parameter bit                WRITE_BACK = 1'b1,
   parameter logic [DATA_W-1:0] MEM_INIT   = '0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CACHES-1:0]        req_valid,
   input  logic [NUM_CACHES-1:0]        req_write,
   input  logic [NUM_CACHES*DATA_W-1:0] req_wdata,
   output logic [NUM_CACHES-1:0]        grant,
   output logic [1:0]                   bus_op,
   output logic [NUM_CACHES-1:0]        line_valid,
   output logic [NUM_CACHES-1:0]        line_dirty,
   output logic [NUM_CACHES*DATA_W-1:0] line_data,
   output logic [DATA_W-1:0]            mem_value
);
   localparam int N = NUM_CACHES;

   if (N < 2 || N > 4) begin : g_bad_count
      $error("snoop_inval_ctrl: NUM_CACHES must be 2..4");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("snoop_inval_ctrl: DATA_W must be at least 1");
   end

   logic [N-1:0]      gnt;
   line_st_e          st   [N];
   logic [DATA_W-1:0] val  [N];
   logic [N-1:0]      mod_vec;
   logic              g_write;
   logic [1:0]        g_st_bits;
   logic [DATA_W-1:0] g_wdata;
   logic              owner_hit;
   logic [DATA_W-1:0] owner_data;
   logic [DATA_W-1:0] fill;
   logic [DATA_W-1:0] mem;
   bus_op_e           op;

   snoop_prio_arb #(.N(N)) u_arb (
      .req (req_valid),
      .gnt (gnt)
   );

   // One-hot OR-muxes over the granted agent and the Modified owner.
   always_comb begin
      g_write    = 1'b0;
      g_st_bits  = '0;
      g_wdata    = '0;
      owner_data = '0;
      for (int i = 0; i < N; i++) begin
         g_write    = g_write   | (gnt[i] & req_write[i]);
         g_st_bits  = g_st_bits | ({2{gnt[i]}} & 2'(st[i]));
         g_wdata    = g_wdata   | ({DATA_W{gnt[i]}} & req_wdata[i*DATA_W +: DATA_W]);
         owner_data = owner_data | ({DATA_W{mod_vec[i]}} & val[i]);
      end
   end

   assign owner_hit = |mod_vec;
   assign fill      = owner_hit ? owner_data : mem;

   always_comb begin
      op = BUS_IDLE;
      if (|gnt) begin
         if (g_write) op = (line_st_e'(g_st_bits) == LN_MOD) ? BUS_IDLE : BUS_INVAL;
         else         op = (line_st_e'(g_st_bits) == LN_INV) ? BUS_MISS : BUS_IDLE;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      snoop_line #(
         .DATA_W     (DATA_W),
         .WRITE_BACK (WRITE_BACK)
      ) u_line (
         .clk       (clk),
         .rst_n     (rst_n),
         .own_gnt   (gnt[i]),
         .own_write (req_write[i]),
         .own_wdata (req_wdata[i*DATA_W +: DATA_W]),
         .fill_data (fill),
         .bus_op    (op),
         .st        (st[i]),
         .val       (val[i])
      );
      assign mod_vec[i]                    = (st[i] == LN_MOD);
      assign line_valid[i]                 = (st[i] != LN_INV);
      assign line_dirty[i]                 = mod_vec[i];
      assign line_data[i*DATA_W +: DATA_W] = val[i];
   end

   snoop_backing #(
      .DATA_W     (DATA_W),
      .WRITE_BACK (WRITE_BACK),
      .MEM_INIT   (MEM_INIT)
   ) u_mem (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_op     (op),
      .wr_data    (g_wdata),
      .owner_hit  (owner_hit),
      .owner_data (owner_data),
      .mem        (mem)
   );

   assign grant     = gnt;
   assign bus_op    = 2'(op);
   assign mem_value = mem;

endmodule

// File: rtl/snoop_inval_chk.sv
module snoop_inval_chk #(
   parameter int N          = 3,
   parameter int DATA_W     = 8,
   parameter bit WRITE_BACK = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [N-1:0]        req_valid,
   input logic [N-1:0]        req_write,
   input logic [N-1:0]        grant,
   input logic [1:0]          bus_op,
   input logic [N-1:0]        line_valid,
   input logic [N-1:0]        line_dirty,
   input logic [N*DATA_W-1:0] line_data,
   input logic [DATA_W-1:0]   mem_value
);
   a_r9_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   a_r9_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req_valid) == '0);

   a_r9_grant_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_valid) |-> (|grant));

   a_r2_miss_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_op == 2'd1) |=> ((line_valid & $past(grant)) == $past(grant)));

   a_r3_read_hit_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grant & ~req_write & line_valid)) |-> (bus_op == 2'd0));

   a_r4_single_holder: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_op == 2'd2) |=> (line_valid == $past(grant)));

   a_r11_one_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(line_dirty));

   a_r11_dirty_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (line_dirty & ~line_valid) == '0);

   if (WRITE_BACK) begin : g_wb_chk
      a_r6_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_op == 2'd2) |=> $stable(mem_value));

      a_r8_mod_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
         (|(grant & req_write & line_dirty)) |-> (bus_op == 2'd0));
   end else begin : g_wt_chk
      a_r10_never_dirty: assert property (@(posedge clk) disable iff (!rst_n)
         line_dirty == '0);

      for (genvar i = 0; i < N; i++) begin : g_coh
         a_r10_matches_mem: assert property (@(posedge clk) disable iff (!rst_n)
            line_valid[i] |-> (line_data[i*DATA_W +: DATA_W] == mem_value));
      end
   end

endmodule

bind snoop_inval_ctrl snoop_inval_chk #(
   .N          (NUM_CACHES),
   .DATA_W     (DATA_W),
   .WRITE_BACK (WRITE_BACK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .grant      (grant),
   .bus_op     (bus_op),
   .line_valid (line_valid),
   .line_dirty (line_dirty),
   .line_data  (line_data),
   .mem_value  (mem_value)
);

// File: tb/test_snoop_inval_ctrl.sv
`timescale 1ns/1ps
module test_snoop_inval_ctrl;
   localparam int N = 3;
   localparam int W = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   req_valid = '0;
   logic [N-1:0]   req_write = '0;
   logic [N*W-1:0] req_wdata = '0;

   logic [N-1:0]   o_gnt [2];
   logic [1:0]     o_op  [2];
   logic [N-1:0]   o_vld [2];
   logic [N-1:0]   o_drt [2];
   logic [N*W-1:0] o_dat [2];
   logic [W-1:0]   o_mem [2];

   int vectors = 0;
   int fails   = 0;

   // Model: index 0 write-through, index 1 write-back. State 0 I, 1 S, 2 M.
   int          m_st  [2][N];
   logic [W-1:0] m_val [2][N];
   logic [W-1:0] m_mem [2];
   string       mtag  [2];

   always #10 clk = ~clk;

   snoop_inval_ctrl #(.NUM_CACHES(N), .DATA_W(W), .WRITE_BACK(1'b0)) i_snoop_inval_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_wdata(req_wdata), .grant(o_gnt[0]), .bus_op(o_op[0]),
      .line_valid(o_vld[0]), .line_dirty(o_drt[0]), .line_data(o_dat[0]),
      .mem_value(o_mem[0]));

   snoop_inval_ctrl #(.NUM_CACHES(N), .DATA_W(W), .WRITE_BACK(1'b1)) i_snoop_inval_ctrl_wb (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_wdata(req_wdata), .grant(o_gnt[1]), .bus_op(o_op[1]),
      .line_valid(o_vld[1]), .line_dirty(o_drt[1]), .line_data(o_dat[1]),
      .mem_value(o_mem[1]));

   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   // Compare grant and bus op for the current inputs, then advance the model.
   task automatic predict(input int d);
      int g = -1;
      int owner = -1;
      bit wb = (d == 1);
      for (int i = N - 1; i >= 0; i--) if (req_valid[i]) g = i;
      chk("R9 grant", int'(o_gnt[d]), (g < 0) ? 0 : (1 << g));
      mtag[d] = wb ? "R6 mem" : "R5 mem";
      if (g < 0) begin
         chk("R1 idle op", int'(o_op[d]), 0);
         return;
      end
      if (req_write[g]) begin
         if (wb && m_st[d][g] == 2) begin
            chk("R8 silent write", int'(o_op[d]), 0);
            mtag[d] = "R8 mem";
         end else begin
            chk("R4 inval op", int'(o_op[d]), 2);
         end
         for (int i = 0; i < N; i++) if (i != g) m_st[d][i] = 0;
         m_val[d][g] = req_wdata[g*W +: W];
         m_st[d][g]  = wb ? 2 : 1;
         if (!wb) m_mem[d] = req_wdata[g*W +: W];
      end else if (m_st[d][g] == 0) begin
         chk("R2 miss op", int'(o_op[d]), 1);
         for (int i = 0; i < N; i++) if (m_st[d][i] == 2) owner = i;
         if (owner >= 0) begin
            m_val[d][g]     = m_val[d][owner];
            m_mem[d]        = m_val[d][owner];
            m_st[d][owner]  = 1;
            mtag[d]         = "R7 mem";
         end else begin
            m_val[d][g] = m_mem[d];
         end
         m_st[d][g] = 1;
      end else begin
         chk("R3 hit op", int'(o_op[d]), 0);
      end
   endtask

   task automatic check_state(input int d);
      int nd = 0;
      for (int i = 0; i < N; i++) begin
         chk("R4 valid", int'(o_vld[d][i]), int'(m_st[d][i] != 0));
         chk(d == 0 ? "R10 dirty" : "R6 dirty", int'(o_drt[d][i]), int'(m_st[d][i] == 2));
         if (m_st[d][i] != 0) chk("R2 data", int'(o_dat[d][i*W +: W]), int'(m_val[d][i]));
         if (o_drt[d][i]) nd++;
      end
      chk("R11 dirty count", int'(nd <= 1), 1);
      chk(mtag[d], int'(o_mem[d]), int'(m_mem[d]));
   endtask

   task automatic cycle(input logic [N-1:0] v, input logic [N-1:0] w, input logic [N*W-1:0] wd);
      @(negedge clk);
      check_state(0);
      check_state(1);
      req_valid = v;
      req_write = w;
      req_wdata = wd;
      #1;
      predict(0);
      predict(1);
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
   end

   initial begin
      logic [31:0] rs = 32'h1234_5678;
      for (int d = 0; d < 2; d++) begin
         m_mem[d] = '0;
         mtag[d]  = "R1 mem";
         for (int i = 0; i < N; i++) begin m_st[d][i] = 0; m_val[d][i] = '0; end
      end
      repeat (3) @(negedge clk);
      for (int d = 0; d < 2; d++) begin
         chk("R1 valid", int'(o_vld[d]), 0);
         chk("R1 dirty", int'(o_drt[d]), 0);
         chk("R1 data", int'(o_dat[d]), 0);
         chk("R1 mem", int'(o_mem[d]), 0);
         chk("R1 op", int'(o_op[d]), 0);
      end
      rst_n = 1'b1;

      // Directed: misses, invalidate, supplied miss, silent write, hit, priority.
      cycle(3'b001, 3'b000, 24'h0);
      cycle(3'b010, 3'b000, 24'h0);
      cycle(3'b001, 3'b001, 24'h000011);
      cycle(3'b010, 3'b000, 24'h0);
      cycle(3'b100, 3'b100, 24'h220000);
      cycle(3'b100, 3'b100, 24'h330000);
      cycle(3'b100, 3'b000, 24'h0);
      cycle(3'b110, 3'b010, 24'h004400);
      cycle(3'b100, 3'b000, 24'h0);
      cycle(3'b111, 3'b111, 24'h665544);
      cycle(3'b110, 3'b110, 24'h665544);
      cycle(3'b100, 3'b100, 24'h665544);
      cycle(3'b011, 3'b000, 24'h0);
      cycle(3'b010, 3'b000, 24'h0);

      // Sweep: pseudo-random request patterns.
      for (int k = 0; k < 3000; k++) begin
         rs ^= rs << 13;
         rs ^= rs >> 17;
         rs ^= rs << 5;
         cycle(rs[2:0], rs[5:3] & {3{rs[6]}}, rs[31:8]);
      end
      cycle('0, '0, '0);
      @(negedge clk);
      check_state(0);
      check_state(1);
      summary();
   end

endmodule